// File: doc/BRIEF.md
# Sticky Interrupt Flag and Enable Register

This block holds the interrupt status of a memory-mapped peripheral. Each event source inside the peripheral gives a one-cycle strobe, and that strobe latches a flag bit. The flag then stays set until the CPU acknowledges it, so an event cannot be lost, however short its strobe.

An enable mask picks which flags may pull the shared interrupt request low. The active-low request goes to a line that several peripherals drive together, and the line is low while any of them holds an enabled flag. A flag that is still set when the handler returns keeps the request asserted, so the CPU is interrupted again.

The acknowledge style is chosen at build time. In read-acknowledge mode, reading the status register clears every flag at the end of that read cycle. In write-ones mode, writing a 1 to a status bit clears that flag in the write cycle.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset all flags and all enable bits are 0, `irq_n_o` is 1, and both registers read as 0.
- R2: A 1 on `evt_i[i]` at a clock edge sets flag i at that edge. The flag stays set through any cycles that carry no acknowledging access.
- R3: `irq_n_o` is 0 exactly while some flag and its enable bit are both 1. A flag whose enable bit is 0 does not assert `irq_n_o`, but it asserts it in the cycle after a write sets that enable bit.
- R4: A read at address 0 returns the flags in bits [NUM_SRC-1:0] and the inverse of `irq_n_o` in bit DATA_W-1. A read at address 1 returns the enable bits in bits [NUM_SRC-1:0] with bit DATA_W-1 at 0. All other bits read 0, and read data is valid in the same cycle as the address.
- R5: With ACK_MODE = ACK_ON_READ, a cycle with `bus_rd`=1 at address 0 returns the flags before the clear and clears all flags at the end of that cycle. A write to address 0 changes no flag.
- R6: With ACK_MODE = ACK_WRITE_ONES, a write to address 0 clears each flag whose data bit is 1 at the end of that cycle and leaves the others unchanged. A read changes no flag.
- R7: If an event strobe and an acknowledge for the same flag fall in the same cycle, the flag is set afterwards.
- R8: A write to address 1 with data bit DATA_W-1 = 1 sets each enable bit whose data bit is 1. With that bit 0, it clears each enable bit whose data bit is 1. Enable bits whose data bit is 0 keep their value, so writing 0x7F disables every source.
- R9: After one flag is acknowledged, `irq_n_o` stays 0 while another enabled flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register select: 0 is status, 1 is enable |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data (combinational) |
| evt_i | input | NUM_SRC | Per-source event strobes |
| irq_n_o | output | 1 | Interrupt request, active low, for a shared wired-OR line |

## Verification
The hardest case to reach is an event strobe that lands in the same cycle as the acknowledge that would clear its flag. From the outside this can only be seen one cycle later, in the status readback. The bench drives a strobe and the acknowledging access together on purpose, in both acknowledge styles. It also combines that with partial write-ones acknowledges, which must leave the request asserted while another enabled flag is still pending. A long pseudo-random stretch follows, with reads, writes and events overlapping in every combination, and a behavioural model judges every cycle.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
   typedef enum logic {
      ACK_ON_READ    = 1'b0,
      ACK_WRITE_ONES = 1'b1
   } ack_mode_e;

   localparam int unsigned STATUS_ADDR = 0;
   localparam int unsigned ENABLE_ADDR = 1;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_SRC = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt,
   input  logic [NUM_SRC-1:0] clr,
   output logic [NUM_SRC-1:0] flags_q
);
   // One sticky cell per source; a new event takes priority over a clear.
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_q[i] <= 1'b0;
         else if (evt[i])
            flags_q[i] <= 1'b1;
         else if (clr[i])
            flags_q[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int unsigned NUM_SRC = 7,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NUM_SRC-1:0] mask_q
);
   localparam int unsigned SEL_BIT = DATA_W - 1;

   logic [NUM_SRC-1:0] bits;
   logic [NUM_SRC-1:0] mask_d;

   assign bits = wdata[NUM_SRC-1:0];

   always_comb begin
      if (wdata[SEL_BIT])
         mask_d = mask_q | bits;
      else
         mask_d = mask_q & ~bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_q <= '0;
      else if (wr_en)
         mask_q <= mask_d;
   end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
   parameter int unsigned NUM_SRC = 7,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               sel_status,
   input  logic               sel_enable,
   input  logic [NUM_SRC-1:0] flags,
   input  logic [NUM_SRC-1:0] mask,
   input  logic               pending,
   output logic [DATA_W-1:0]  rdata
);
   always_comb begin
      rdata = '0;
      if (sel_status) begin
         rdata[NUM_SRC-1:0] = flags;
         rdata[DATA_W-1]    = pending;
      end else if (sel_enable) begin
         rdata[NUM_SRC-1:0] = mask;
      end
   end
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
   import irq_flag_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 1,
   parameter ack_mode_e   ACK_MODE = ACK_ON_READ
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_rd,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] evt_i,
   output logic               irq_n_o
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ENABLE_ADDR);

   if (NUM_SRC < 1 || NUM_SRC > DATA_W - 1) begin : g_bad_src
      $error("NUM_SRC must lie in 1..DATA_W-1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end

   logic               sel_status;
   logic               sel_enable;
   logic [NUM_SRC-1:0] clr;
   logic [NUM_SRC-1:0] flags_q;
   logic [NUM_SRC-1:0] mask_q;
   logic               pending;

   assign sel_status = (bus_addr == A_STATUS);
   assign sel_enable = (bus_addr == A_ENABLE);

   if (ACK_MODE == ACK_ON_READ) begin : g_ack_rd
      assign clr = {NUM_SRC{bus_rd & sel_status}};
   end else begin : g_ack_w1
      assign clr = (bus_wr & sel_status) ? bus_wdata[NUM_SRC-1:0] : '0;
   end

   irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt_i),
      .clr     (clr),
      .flags_q (flags_q)
   );

   irq_mask_reg #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bus_wr & sel_enable),
      .wdata  (bus_wdata),
      .mask_q (mask_q)
   );

   assign pending = |(flags_q & mask_q);
   assign irq_n_o = ~pending;

   irq_rd_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
      .sel_status (sel_status),
      .sel_enable (sel_enable),
      .flags      (flags_q),
      .mask       (mask_q),
      .pending    (pending),
      .rdata      (bus_rdata)
   );
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk
   import irq_flag_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 7,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned ADDR_W   = 1,
   parameter ack_mode_e   ACK_MODE = ACK_ON_READ
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_rd,
   input logic               bus_wr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               irq_n_o,
   input logic [NUM_SRC-1:0] flags_q,
   input logic [NUM_SRC-1:0] mask_q
);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(ENABLE_ADDR);

   // R2
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd || bus_wr) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // R3
   evt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((evt_i & mask_q) != '0) && !bus_wr) |=> !irq_n_o);

   // R4
   summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == A_STATUS) |-> (bus_rdata[DATA_W-1] == !irq_n_o));

   // R7
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((flags_q & $past(evt_i)) == $past(evt_i)));

   // R8
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_ENABLE && !bus_wdata[DATA_W-1])
      |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0));

   if (ACK_MODE == ACK_ON_READ) begin : g_rd
      // R5
      rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_rd && bus_addr == A_STATUS) |=> ((flags_q & ~$past(evt_i)) == '0));
   end else begin : g_w1
      // R6
      w1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == A_STATUS)
         |=> ((flags_q & $past(bus_wdata[NUM_SRC-1:0]) & ~$past(evt_i)) == '0));
   end
endmodule

bind irq_flag_reg irq_flag_reg_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACK_MODE(ACK_MODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
   .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .evt_i(evt_i), .irq_n_o(irq_n_o), .flags_q(flags_q), .mask_q(mask_q)
);

// File: tb/irq_flag_reg_tb.sv
module irq_flag_reg_tb;
   import irq_flag_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [0:0] bus_addr = '0;
   logic       bus_rd = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [6:0] evt_i = '0;
   logic [7:0] rdata_a, rdata_b;
   logic       irq_a, irq_b;

   int checks = 0;
   int errors = 0;
   // Model state: index 0 is read-acknowledge, index 1 is write-ones
   int flg [2];
   int msk [2];

   always #10 clk = ~clk;

   irq_flag_reg #(.ACK_MODE(ACK_ON_READ)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
      .evt_i(evt_i), .irq_n_o(irq_a));

   irq_flag_reg #(.ACK_MODE(ACK_WRITE_ONES)) u_dut_w1c (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
      .evt_i(evt_i), .irq_n_o(irq_b));

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_rdata(int m);
      int pend = ((flg[m] & msk[m]) != 0) ? 1 : 0;
      if (bus_addr == 1'b0) return flg[m] | (pend << 7);
      return msk[m];
   endfunction

   function automatic int exp_irq(int m);
      return ((flg[m] & msk[m]) != 0) ? 0 : 1;
   endfunction

   // One bus cycle: drive, compare both DUTs, clock, advance the model
   task automatic cyc(string tag, int addr, bit rd, bit wr, int wd, int ev);
      @(negedge clk);
      bus_addr  = addr[0:0];
      bus_rd    = rd;
      bus_wr    = wr;
      bus_wdata = wd[7:0];
      evt_i     = ev[6:0];
      #5;
      chk({tag, " rd-ack rdata"}, int'(rdata_a), exp_rdata(0));
      chk({tag, " rd-ack irq_n"}, int'(irq_a), exp_irq(0));
      chk({tag, " w1c rdata"}, int'(rdata_b), exp_rdata(1));
      chk({tag, " w1c irq_n"}, int'(irq_b), exp_irq(1));
      @(posedge clk);
      #1;
      for (int m = 0; m < 2; m++) begin
         int clr = 0;
         if (m == 0 && rd && addr == 0) clr = 'h7F;
         if (m == 1 && wr && addr == 0) clr = wd & 'h7F;
         flg[m] = (flg[m] & ~clr) | (ev & 'h7F);
         if (wr && addr == 1) begin
            if (wd[7]) msk[m] = msk[m] | (wd & 'h7F);
            else       msk[m] = msk[m] & ~(wd & 'h7F);
         end
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      int seed = 7;
      flg = '{0, 0};
      msk = '{0, 0};
      repeat (3) @(posedge clk);
      // R1: reset state, both registers and the request
      cyc("R1", 0, 0, 0, 0, 0);
      cyc("R1", 1, 0, 0, 0, 0);
      rst_n = 1'b1;
      cyc("R1", 0, 1, 0, 0, 0);
      // R2: event latches and holds while no access happens
      cyc("R2", 1, 0, 0, 0, 'h01);
      cyc("R2", 0, 0, 0, 0, 0);
      cyc("R2", 0, 0, 0, 0, 0);
      // R3: a disabled flag stays quiet, then asserts once enabled
      cyc("R3", 1, 0, 1, 'h81, 0);
      cyc("R3", 0, 0, 0, 0, 0);
      cyc("R3", 0, 0, 0, 0, 'h04);
      cyc("R8", 1, 0, 1, 'h84, 0);
      cyc("R8", 1, 0, 0, 0, 0);
      // R4: readback at both addresses
      cyc("R4", 0, 1, 0, 0, 0);
      cyc("R4", 1, 1, 0, 0, 0);
      // R5 / R6: the other style's acknowledge must not clear
      cyc("R6", 0, 0, 1, 'h01, 0);
      cyc("R5", 0, 0, 0, 0, 0);
      cyc("R5", 0, 0, 0, 0, 'h05);
      cyc("R5", 0, 1, 0, 0, 0);
      cyc("R5", 0, 0, 0, 0, 0);
      // R7: event and acknowledge in the same cycle
      cyc("R7", 0, 1, 0, 0, 'h02);
      cyc("R7", 0, 0, 1, 'h02, 'h02);
      cyc("R7", 0, 0, 0, 0, 0);
      // R8: 0x7F disables all sources
      cyc("R8", 1, 0, 1, 'h7F, 0);
      cyc("R8", 1, 0, 0, 0, 0);
      cyc("R8", 0, 0, 0, 0, 0);
      // R9: partial acknowledge leaves the request asserted
      cyc("R9", 1, 0, 1, 'hFF, 'h7F);
      cyc("R9", 0, 0, 1, 'h01, 0);
      cyc("R9", 0, 0, 0, 0, 0);
      cyc("R9", 0, 0, 1, 'h7E, 0);
      cyc("R9", 0, 0, 0, 0, 0);
      // Mixed pseudo-random traffic
      for (int k = 0; k < 400; k++) begin
         int r = $urandom(seed + k);
         cyc("R4 mix", r & 1, r[1] & r[2], r[3] & r[4], (r >> 8) & 'hFF,
             ((r >> 16) & (r >> 24)) & 'h7F);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule